// File: doc/BRIEF.md
# Buffered Serial Transmitter with Deferred Disable

This block is the transmit half of an asynchronous serial port. Software writes a character into a one-entry holding buffer. As soon as the shifter is free, the character moves into a shift register that drives the serial line. The frame is a low start bit, the data bits with the least significant bit first, an optional ninth bit, and one high stop bit. Each bit lasts a fixed number of pulses of an external baud tick: 16 pulses in normal speed, or 8 when double speed is selected.

Two status flags report progress. The buffer-free flag means a new character may be written. The done flag means the last character has fully left the line and nothing is waiting. Each flag has its own interrupt request, and each request is gated by a per-source enable bit and a global enable. When software clears the transmit enable, the transmitter does not stop at once. It keeps ownership of the pin until the character on the wire and the one in the buffer have both been sent.

Top module: `uart_tx_defer`

## Requirements
- R1: After reset, `txLine` is 1, `pinOverride` is 0, `dreFlag` is 1, `txcFlag` is 0 and both interrupt requests are 0. The line stays 1 whenever the pin is not overridden.
- R2: A frame is sent as follows. First a start bit of 0. Then the 8 data bits, least significant bit first. Then, if control bit 2 is 1, a ninth bit whose value is control bit 0, as it stands when the frame starts. Last, one stop bit of 1.
- R3: Each bit lasts 16 `baudTick` pulses when `dblSpeed` is 0 and 8 pulses when it is 1. With `baudTick` held at 1, `txcFlag` is first seen high at the (L*P+2)th falling clock edge after the data write is driven, where L is the frame length in bits and P is the bit length in ticks.
- R4: A data write while the transmit enable (control bit 3) is 1 and `dreFlag` is 1 clears `dreFlag` on the next edge. The buffer then moves to the shifter on the following edge if the shifter is idle, and `dreFlag` returns to 1.
- R5: Writes made while `dreFlag` is 0, or while the transmit enable is 0, are dropped.
- R6: `txcFlag` is set when a stop bit ends with the buffer empty. It is cleared by a `txcClr` pulse or by the start of a new frame.
- R7: `pinOverride` is 1 while the transmit enable is 1, and also while a character is being shifted or is waiting in the buffer. Clearing the enable during a send releases the pin only after both pending characters have gone out.
- R8: `dreIrq` equals control bit 5 AND `globalIe` AND `dreFlag`. `txcIrq` equals control bit 6 AND `globalIe` AND `txcFlag`.
- R9: A character waiting in the buffer starts on the edge that ends the previous stop bit, with no idle gap. `txcFlag` is not set between the two frames.
- R10: Control bits 7 and 4 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWr | input | 1 | Control register write strobe |
| ctrlData | input | 8 | Control value (bit 6 done IE, bit 5 buffer IE, bit 3 enable, bit 2 ninth-bit enable, bit 0 ninth bit) |
| dataWr | input | 1 | Data register write strobe |
| dataIn | input | 8 | Character to send |
| txcClr | input | 1 | Clears the done flag |
| baudTick | input | 1 | Oversampling tick from the baud divider |
| dblSpeed | input | 1 | Selects 8 ticks per bit instead of 16 |
| globalIe | input | 1 | Global interrupt enable |
| txLine | output | 1 | Serial output, idles high |
| pinOverride | output | 1 | Transmitter owns the pin |
| dreFlag | output | 1 | Holding buffer is free |
| txcFlag | output | 1 | Transmission complete |
| dreIrq | output | 1 | Buffer-free interrupt request |
| txcIrq | output | 1 | Done interrupt request |

## Verification
The bench targets the disable written in the middle of a two-character burst. A design that honoured the disable at once would drop `pinOverride` early or truncate the second frame. Back-to-back characters are decoded from the line to catch a design that inserts an idle gap, or that raises the done flag between frames. The bench times the done flag to the exact cycle at both bit lengths, which exposes an off-by-one in the tick or bit counters. Writes into a full buffer and writes while disabled are checked to leave no trace on the line.

// File: rtl/uart_tx_defer_pkg.sv
package uart_tx_defer_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // buffer takes dataIn
    logic load;     // buffer moves into the shifter
    logic shift;    // one bit period ended
  } txStrobe_t;
endpackage

// File: rtl/uart_tx_defer_ctrl.sv
module uart_tx_defer_ctrl
  import uart_tx_defer_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      ctrlWr,
  input  logic [7:0] ctrlData,
  input  logic      dataWr,
  input  logic      txcClr,
  input  logic      baudTick,
  input  logic      dblSpeed,
  input  logic      globalIe,
  output txStrobe_t stb,
  output logic      busy,
  output logic      txEn,
  output logic      ninthEn,
  output logic      ninthVal,
  output logic      dreFlag,
  output logic      txcFlag,
  output logic      dreIrq,
  output logic      txcIrq,
  output logic      pinOverride
);
  localparam int CW = $clog2(OVS);
  localparam int BW = $clog2(DW + 3);

  logic          txcIe, dreIe, bufFull;
  logic [CW-1:0] tickCnt, lim;
  logic [BW-1:0] bitCnt, frameLast;
  logic          lastTick, bitEnd, frameDone, load, capture;

  assign lim       = dblSpeed ? CW'(OVS / 2 - 1) : CW'(OVS - 1);
  assign lastTick  = baudTick && (tickCnt >= lim);
  assign bitEnd    = busy && lastTick;
  assign frameDone = bitEnd && (bitCnt == frameLast);
  assign load      = bufFull && (!busy || frameDone);
  assign capture   = dataWr && txEn && !bufFull;

  assign stb = '{capture: capture, load: load, shift: bitEnd};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txcIe <= 1'b0; dreIe <= 1'b0; txEn <= 1'b0;
      ninthEn <= 1'b0; ninthVal <= 1'b0;
    end else if (ctrlWr) begin
      txcIe    <= ctrlData[6];
      dreIe    <= ctrlData[5];
      txEn     <= ctrlData[3];
      ninthEn  <= ctrlData[2];
      ninthVal <= ctrlData[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy      <= 1'b0;
      bufFull   <= 1'b0;
      tickCnt   <= '0;
      bitCnt    <= '0;
      frameLast <= '0;
      txcFlag   <= 1'b0;
    end else begin
      if (load)           busy <= 1'b1;
      else if (frameDone) busy <= 1'b0;

      if (load)         bufFull <= 1'b0;
      else if (capture) bufFull <= 1'b1;

      if (load)                  tickCnt <= '0;
      else if (busy && baudTick) tickCnt <= lastTick ? '0 : tickCnt + 1'b1;

      if (load) begin
        bitCnt    <= '0;
        frameLast <= ninthEn ? BW'(DW + 2) : BW'(DW + 1);
      end else if (bitEnd) begin
        bitCnt <= bitCnt + 1'b1;
      end

      if (frameDone && !bufFull) txcFlag <= 1'b1;
      else if (load || txcClr)   txcFlag <= 1'b0;
    end
  end

  assign dreFlag     = !bufFull;
  assign dreIrq      = dreIe & globalIe & dreFlag;
  assign txcIrq      = txcIe & globalIe & txcFlag;
  assign pinOverride = txEn | busy | bufFull;
endmodule

// File: rtl/uart_tx_defer_dp.sv
module uart_tx_defer_dp
  import uart_tx_defer_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  txStrobe_t     stb,
  input  logic [DW-1:0] dataIn,
  input  logic          ninthEn,
  input  logic          ninthVal,
  output logic          txLine
);
  localparam int FW = DW + 3;

  logic [DW-1:0] bufData;
  logic [FW-1:0] shiftReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufData  <= '0;
      shiftReg <= '1;
    end else begin
      if (stb.capture) bufData <= dataIn;
      if (stb.load)
        shiftReg <= {1'b1, (ninthEn ? ninthVal : 1'b1), bufData, 1'b0};
      else if (stb.shift)
        shiftReg <= {1'b1, shiftReg[FW-1:1]};
    end
  end

  assign txLine = shiftReg[0];
endmodule

// File: rtl/uart_tx_defer.sv
module uart_tx_defer
  import uart_tx_defer_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          ctrlWr,
  input  logic [7:0]    ctrlData,
  input  logic          dataWr,
  input  logic [DW-1:0] dataIn,
  input  logic          txcClr,
  input  logic          baudTick,
  input  logic          dblSpeed,
  input  logic          globalIe,
  output logic          txLine,
  output logic          pinOverride,
  output logic          dreFlag,
  output logic          txcFlag,
  output logic          dreIrq,
  output logic          txcIrq
);
  txStrobe_t stb;
  logic busy, txEnBit, ninthEn, ninthVal;

  uart_tx_defer_ctrl #(.DW(DW), .OVS(OVS)) ctrl_i (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .ctrlData(ctrlData),
    .dataWr(dataWr), .txcClr(txcClr), .baudTick(baudTick),
    .dblSpeed(dblSpeed), .globalIe(globalIe), .stb(stb), .busy(busy),
    .txEn(txEnBit), .ninthEn(ninthEn), .ninthVal(ninthVal),
    .dreFlag(dreFlag), .txcFlag(txcFlag), .dreIrq(dreIrq),
    .txcIrq(txcIrq), .pinOverride(pinOverride)
  );

  uart_tx_defer_dp #(.DW(DW)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .dataIn(dataIn),
    .ninthEn(ninthEn), .ninthVal(ninthVal), .txLine(txLine)
  );
endmodule

// File: rtl/uart_tx_defer_chk.sv
module uart_tx_defer_chk (
  input logic clk,
  input logic rstN,
  input logic dataWr,
  input logic globalIe,
  input logic txLine,
  input logic pinOverride,
  input logic dreFlag,
  input logic txcFlag,
  input logic dreIrq,
  input logic txcIrq,
  input logic busy,
  input logic txEnBit
);
  // R1
  idle_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pinOverride |-> txLine);
  // R2
  start_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !txLine);
  // R4
  capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataWr && txEnBit && dreFlag) |=> !dreFlag);
  // R6
  txc_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    txcFlag |-> !busy);
  // R7
  release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pinOverride) |-> (!txEnBit && dreFlag && !busy));
  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dreIrq || txcIrq) |-> globalIe);
endmodule

bind uart_tx_defer uart_tx_defer_chk chk_i (
  .clk(clk), .rstN(rstN), .dataWr(dataWr), .globalIe(globalIe),
  .txLine(txLine), .pinOverride(pinOverride), .dreFlag(dreFlag),
  .txcFlag(txcFlag), .dreIrq(dreIrq), .txcIrq(txcIrq),
  .busy(busy), .txEnBit(txEnBit)
);

// File: tb/uart_tx_defer_tb_top.sv
module uart_tx_defer_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctrlWr = 1'b0, dataWr = 1'b0, txcClr = 1'b0;
  logic baudTick = 1'b1, dblSpeed = 1'b0, globalIe = 1'b0;
  logic [7:0] ctrlData = 8'h00, dataIn = 8'h00;
  logic txLine, pinOverride, dreFlag, txcFlag, dreIrq, txcIrq;

  always #4 clk = ~clk;

  uart_tx_defer dut_i (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .ctrlData(ctrlData),
    .dataWr(dataWr), .dataIn(dataIn), .txcClr(txcClr), .baudTick(baudTick),
    .dblSpeed(dblSpeed), .globalIe(globalIe), .txLine(txLine),
    .pinOverride(pinOverride), .dreFlag(dreFlag), .txcFlag(txcFlag),
    .dreIrq(dreIrq), .txcIrq(txcIrq)
  );

  int nChk = 0, nBad = 0;
  int curBits = 8, curPer = 16;
  int rxCnt = 0;
  logic [8:0] rxData [0:31];
  logic       rxOk   [0:31];

  // {dblSpeed, ninthEn, ninthVal, data}
  localparam logic [10:0] VEC [6] = '{
    {3'b000, 8'hA5}, {3'b000, 8'h01}, {3'b100, 8'h80},
    {3'b011, 8'h3C}, {3'b010, 8'hFF}, {3'b111, 8'h00}
  };

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wrCtrl(input logic [7:0] v);
    @(negedge clk); ctrlWr = 1'b1; ctrlData = v;
    @(negedge clk); ctrlWr = 1'b0;
  endtask

  task automatic wrData(input logic [7:0] v);
    @(negedge clk); dataWr = 1'b1; dataIn = v;
    @(negedge clk); dataWr = 1'b0;
  endtask

  task automatic waitTxc(output int n);
    n = 0;
    while (!txcFlag && n < 2000) begin @(negedge clk); n++; end
  endtask

  task automatic pulseClr();
    @(negedge clk); txcClr = 1'b1;
    @(negedge clk); txcClr = 1'b0;
  endtask

  // line decoder
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && txLine === 1'b0) begin
        logic [8:0] v;
        logic ok;
        v = '0;
        repeat (curPer / 2) @(negedge clk);
        ok = (txLine == 1'b0);
        for (int i = 0; i < curBits; i++) begin
          repeat (curPer) @(negedge clk);
          v[i] = txLine;
        end
        repeat (curPer) @(negedge clk);
        rxData[rxCnt] = v;
        rxOk[rxCnt] = ok && txLine;
        rxCnt++;
      end
    end
  end

  initial begin
    repeat (300000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    int n, base, expLen;
    logic [8:0] expV;
    logic early;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(txLine && !pinOverride && dreFlag && !txcFlag && !dreIrq && !txcIrq,
        "R1 reset", {txLine, pinOverride, dreFlag, txcFlag, dreIrq, txcIrq}, 6'b101000);

    // table of frames: R2, R3, R4
    for (int k = 0; k < 6; k++) begin
      dblSpeed = VEC[k][10];
      curPer   = VEC[k][10] ? 8 : 16;
      curBits  = VEC[k][9] ? 9 : 8;
      expLen   = curBits + 2;
      expV     = VEC[k][9] ? {VEC[k][8], VEC[k][7:0]} : {1'b0, VEC[k][7:0]};
      wrCtrl({4'b0000, 1'b1, VEC[k][9], 1'b0, VEC[k][8]});
      base = rxCnt;
      wrData(VEC[k][7:0]);
      chk(!dreFlag, "R4 flag clears on write", dreFlag, 0);
      @(negedge clk);
      chk(dreFlag && !txLine, "R4 buffer moves to shifter", {dreFlag, txLine}, 2'b10);
      waitTxc(n);
      chk(n + 2 == expLen * curPer + 2, "R3 frame length", n + 2, expLen * curPer + 2);
      repeat (3) @(negedge clk);
      chk(rxCnt == base + 1 && rxData[base] == expV && rxOk[base],
          "R2 frame content", rxData[base], expV);
      pulseClr();
      chk(!txcFlag, "R6 cleared by txcClr", txcFlag, 0);
    end
    dblSpeed = 1'b0; curPer = 16; curBits = 8;

    // deferred disable with two pending characters: R7, R9
    wrCtrl(8'h08);
    base = rxCnt;
    wrData(8'h5A);
    @(negedge clk);
    wrData(8'hC3);
    wrCtrl(8'h00);
    chk(pinOverride, "R7 override held after disable", pinOverride, 1);
    early = 1'b0;
    n = 0;
    while (!txcFlag && n < 2000) begin
      @(negedge clk); n++;
      if (!pinOverride && !txcFlag) early = 1'b1;
      if (txcFlag && rxCnt < base + 1) early = 1'b1;
    end
    chk(!early, "R9 no early release or early done", early, 0);
    chk(!pinOverride, "R7 override released at end", pinOverride, 0);
    repeat (3) @(negedge clk);
    chk(rxCnt == base + 2 && rxData[base] == 9'h05A && rxData[base + 1] == 9'h0C3,
        "R9 back-to-back frames", rxData[base + 1], 9'h0C3);

    // interrupt gating: R8
    wrCtrl(8'h40);
    globalIe = 1'b0;
    @(negedge clk);
    chk(!txcIrq, "R8 txc irq gated by global", txcIrq, 0);
    globalIe = 1'b1;
    @(negedge clk);
    chk(txcIrq, "R8 txc irq", txcIrq, 1);
    pulseClr();
    chk(!txcIrq, "R8 txc irq follows flag", txcIrq, 0);
    wrCtrl(8'h20);
    chk(dreIrq && !txcIrq, "R8 dre irq", {dreIrq, txcIrq}, 2'b10);

    // control bits 7 and 4: R10
    wrCtrl(8'h90);
    @(negedge clk);
    chk(!pinOverride && !dreIrq && !txcIrq && txLine, "R10 bits 7 and 4 inert",
        {pinOverride, dreIrq, txcIrq, txLine}, 4'b0001);

    // write while disabled: R5
    base = rxCnt;
    wrData(8'h77);
    repeat (200) @(negedge clk);
    chk(rxCnt == base && dreFlag && !pinOverride, "R5 write while disabled dropped",
        rxCnt - base, 0);

    // write into full buffer: R5
    wrCtrl(8'h08);
    base = rxCnt;
    wrData(8'h11);
    @(negedge clk);
    wrData(8'h22);
    wrData(8'h33);
    waitTxc(n);
    repeat (3) @(negedge clk);
    chk(rxCnt == base + 2 && rxData[base] == 9'h011 && rxData[base + 1] == 9'h022,
        "R5 write into full buffer dropped", rxCnt - base, 2);
    pulseClr();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule